// File: doc/BRIEF.md
# Wait-State External Bus Controller

This block connects a processor core's single-request port to an external asynchronous memory and I/O bus. It accepts one request at a time. A request carries an address, a direction flag, write data and a flag that marks shared global memory. The block drives the external address, the read and write strobes, the output enable of the bidirectional data bus and a bus-request line. When the access finishes, it returns read data and a one-clock completion pulse to the core.

Reads complete in a single machine cycle when nothing slows them down. Writes always spend one extra setup cycle so that the shared data bus can change direction. The output enable rises half a clock into that setup cycle. An access is stretched by the external ready input, by a software-programmed wait count, or by both. The larger of the two stretches applies, always in whole machine cycles. Global accesses raise the bus-request line from their first cycle and hold it until the far side answers ready.

Top module: `xbus_waitctl`

## Requirements
- R1: With a programmed wait count of 0 and ext_ready high, a read occupies exactly one access cycle with ext_rd high. rsp_rdata returns the value ext_din held at the end of that cycle, and rsp_done is high in the following cycle.
- R2: A write occupies a setup cycle with ext_wr low, followed by at least one strobe cycle with ext_wr high. A zero-wait write therefore takes two cycles.
- R3: ext_doe is low in the first half of the write setup cycle and high in its second half. It stays high for every strobe cycle. It is never high during a read or while idle.
- R4: Each rising clock edge that samples ext_ready low at the end of a read or strobe cycle extends the access by one more cycle. There is no limit on the number of such cycles.
- R5: cfg_we loads cfg_wait into a WAIT_W-bit (default 3-bit, 0 to 7) software wait register. The count is taken at request acceptance. A read then lasts max(count, k)+1 cycles, where k is the number of low ready samples; a write lasts one cycle more.
- R6: For a request with req_global=1, ext_breq is high from the first access cycle until completion and low in the rsp_done cycle. For a request with req_global=0, ext_breq stays low.
- R7: rsp_done is high for exactly one clock. A request is accepted only while idle with rsp_done low, so a held req_valid starts its next access two cycles after the previous access ends.
- R8: ext_addr and ext_dout keep the accepted request's address and write data for the whole access.
- R9: After reset, ext_rd, ext_wr, ext_doe, ext_breq and rsp_done are low and the software wait count is 0. ext_rd and ext_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one machine cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the software wait count |
| cfg_wait | input | WAIT_W | New software wait count |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_global | input | 1 | Access targets global memory |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| ext_addr | output | ADDR_W | External address |
| ext_dout | output | DATA_W | Data driven onto the external bus |
| ext_din | input | DATA_W | Data read from the external bus |
| ext_doe | output | 1 | Data-bus output enable |
| ext_rd | output | 1 | Read strobe, active high |
| ext_wr | output | 1 | Write strobe, active high |
| ext_breq | output | 1 | Global-memory bus request |
| ext_ready | input | 1 | External ready, active high |

## Verification
The bound checker watches every clock edge. It checks that the two strobes are exclusive, that reads never enable the data bus, that the enable covers the strobe cycles and stays high across the edge that ends the setup cycle, and that completion is a single pulse that never follows a low ready sample. It also checks that the address and write data hold steady while a strobe lasts. Only the bench scenarios can show cycle counts, which need a count of how long ready was held low together with the programmed count. The same holds for the half-cycle timing of the enable inside the setup cycle, the captured read value, and the spacing of back-to-back requests.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      XB_IDLE    = 2'd0,
      XB_READ    = 2'd1,
      XB_WSETUP  = 2'd2,
      XB_WSTROBE = 2'd3
   } xb_state_t;
endpackage

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              load,
   input  logic              dec,
   output logic              zero
);
   logic [WAIT_W-1:0] sw_q;
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= '0;
      end else if (cfg_we) begin
         sw_q <= cfg_wait;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= sw_q;
      end else if (dec) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      req_write,
   input  logic      ext_ready,
   input  logic      wait_zero,
   output xb_state_t state,
   output logic      accept,
   output logic      dec,
   output logic      finish,
   output logic      done
);
   xb_state_t st_q, st_d;
   logic      done_q;
   logic      in_access;

   always_comb begin
      in_access = (st_q == XB_READ) || (st_q == XB_WSTROBE);
      accept    = (st_q == XB_IDLE) && req_valid && !done_q;
      finish    = in_access && ext_ready && wait_zero;
      dec       = in_access && !wait_zero;
      st_d      = st_q;
      unique case (st_q)
         XB_IDLE:    if (accept) st_d = req_write ? XB_WSETUP : XB_READ;
         XB_WSETUP:  st_d = XB_WSTROBE;
         XB_READ,
         XB_WSTROBE: if (finish) st_d = XB_IDLE;
         default:    st_d = XB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= XB_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
      end
   end

   assign state = st_q;
   assign done  = done_q;
endmodule

// File: rtl/xbus_turnaround.sv
module xbus_turnaround
   import xbus_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  xb_state_t state,
   output logic      doe
);
   logic half_q;

   // Falling-edge flag: marks the second half of the write setup cycle.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
      end else begin
         half_q <= (state == XB_WSETUP);
      end
   end

   assign doe = ((state == XB_WSETUP) && half_q) || (state == XB_WSTROBE);
endmodule

// File: rtl/xbus_waitctl.sv
module xbus_waitctl
   import xbus_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int WAIT_W     = 3,
   parameter bit RDATA_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_global,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_dout,
   input  logic [DATA_W-1:0] ext_din,
   output logic              ext_doe,
   output logic              ext_rd,
   output logic              ext_wr,
   output logic              ext_breq,
   input  logic              ext_ready
);
   localparam int MAX_SW = (1 << WAIT_W) - 1;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("xbus_waitctl: ADDR_W and DATA_W must be at least 1");
   end
   if (WAIT_W < 1 || MAX_SW > 255) begin : g_bad_wait
      $error("xbus_waitctl: WAIT_W must lie in 1..8");
   end

   xb_state_t         state;
   logic              accept, dec, finish, wait_zero;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              glob_q;

   xbus_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .ext_ready (ext_ready),
      .wait_zero (wait_zero),
      .state     (state),
      .accept    (accept),
      .dec       (dec),
      .finish    (finish),
      .done      (rsp_done)
   );

   xbus_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wait (cfg_wait),
      .load     (accept),
      .dec      (dec),
      .zero     (wait_zero)
   );

   xbus_turnaround u_turn (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .doe   (ext_doe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         glob_q  <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         glob_q  <= req_global;
      end
   end

   if (RDATA_HOLD) begin : g_rd_hold
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else if (finish && state == XB_READ) begin
            rd_q <= ext_din;
         end
      end
      assign rsp_rdata = rd_q;
   end else begin : g_rd_pulse
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= (finish && state == XB_READ) ? ext_din : '0;
         end
      end
      assign rsp_rdata = rd_q;
   end

   assign ext_addr = addr_q;
   assign ext_dout = wdata_q;
   assign ext_rd   = (state == XB_READ);
   assign ext_wr   = (state == XB_WSTROBE);
   assign ext_breq = glob_q && (state != XB_IDLE);
endmodule

// File: rtl/xbus_waitctl_chk.sv
module xbus_waitctl_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [DATA_W-1:0] ext_dout,
   input logic              ext_doe,
   input logic              ext_rd,
   input logic              ext_wr,
   input logic              ext_breq,
   input logic              ext_ready
);
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_rd && ext_wr));

   p_no_doe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |-> !ext_doe);

   p_doe_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr |-> ext_doe);

   p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_wr) |-> ($past(ext_doe) && !$past(ext_rd)));

   p_ready_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_rd || ext_wr) && !ext_ready) |=> !rsp_done);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_breq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !ext_breq);

   p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_rd && $past(ext_rd)) || (ext_wr && $past(ext_wr)))
         |-> ($stable(ext_addr) && $stable(ext_dout)));
endmodule

bind xbus_waitctl xbus_waitctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rsp_done  (rsp_done),
   .ext_addr  (ext_addr),
   .ext_dout  (ext_dout),
   .ext_doe   (ext_doe),
   .ext_rd    (ext_rd),
   .ext_wr    (ext_wr),
   .ext_breq  (ext_breq),
   .ext_ready (ext_ready)
);

// File: tb/xbus_waitctl_tb.sv
`timescale 1ns/1ps
module xbus_waitctl_tb;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int WW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [WW-1:0] cfg_wait = '0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_global = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] ext_addr;
   logic [DW-1:0] ext_dout;
   logic [DW-1:0] ext_din = '0;
   logic          ext_doe, ext_rd, ext_wr, ext_breq;
   logic          ext_ready = 1'b1;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   xbus_waitctl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
      .req_valid(req_valid), .req_write(req_write), .req_global(req_global),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
      .ext_doe(ext_doe), .ext_rd(ext_rd), .ext_wr(ext_wr),
      .ext_breq(ext_breq), .ext_ready(ext_ready));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_waits(input int w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wait = WW'(w);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // One access. lowk = ready samples held low; exp = expected access cycles.
   task automatic access(input string tag, input bit wr, input bit glob, input int lowk,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, input int exp);
      int  cyc = 0;
      int  strobes = 0;
      bit  bad_wr = 0, bad_doe = 0, bad_breq = 0, bad_hold = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_global = glob;
      req_addr = a; req_wdata = d; ext_din = ~d;
      ext_ready = (lowk == 0);
      @(posedge clk);
      #1 req_valid = 1'b0;
      #1;
      while (!rsp_done && cyc < 400) begin
         cyc++;
         if (ext_rd || ext_wr) strobes++;
         // first quarter of the cycle
         if (wr) begin
            if (ext_wr != (cyc > 1) || ext_rd) bad_wr = 1;
            if (ext_doe != (cyc > 1)) bad_doe = 1;
         end else begin
            if (!ext_rd || ext_wr) bad_wr = 1;
            if (ext_doe) bad_doe = 1;
         end
         if (ext_breq != glob) bad_breq = 1;
         if (ext_addr != a || (wr && ext_dout != d)) bad_hold = 1;
         #4;
         // third quarter of the cycle
         if (ext_doe != wr) bad_doe = 1;
         if (strobes > lowk) ext_ready = 1'b1;
         @(posedge clk);
         #2;
      end
      chk(cyc == exp, {tag, " R4 R5 access cycles"}, cyc, exp);
      chk(!bad_wr, {tag, " R2 R9 strobe pattern"}, bad_wr, 0);
      chk(!bad_doe, {tag, " R3 output enable timing"}, bad_doe, 0);
      chk(!bad_breq, {tag, " R6 bus request during access"}, bad_breq, 0);
      chk(!bad_hold, {tag, " R8 address/data held"}, bad_hold, 0);
      chk(rsp_done && !ext_breq && !ext_doe, {tag, " R6 R3 released at done"},
          int'({rsp_done, ext_breq, ext_doe}), 4);
      if (!wr) chk(rsp_rdata == ~d, {tag, " R1 read data"}, int'(rsp_rdata), int'(~d));
      @(posedge clk);
      #2;
      chk(!rsp_done, {tag, " R7 done one clock"}, rsp_done, 0);
      ext_ready = 1'b1;
   endtask

   task automatic t_reset;
      chk(!ext_rd && !ext_wr && !ext_doe && !ext_breq && !rsp_done, "R9 reset outputs low",
          int'({ext_rd, ext_wr, ext_doe, ext_breq, rsp_done}), 0);
   endtask

   task automatic t_reset_waits;
      // R9: wait count resets to 0 -> plain read is one cycle
      access("R9 reset count", 0, 0, 0, 16'h0010, 16'h1111, 1);
   endtask

   task automatic t_held_request;
      int gap = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_global = 1'b0; req_addr = 16'h0777;
      ext_din = 16'h5A5A; ext_ready = 1'b1;
      @(posedge clk); #2;   // after E0: first access
      chk(ext_rd, "R7 held request first read", ext_rd, 1);
      @(posedge clk); #2;   // after E1: done
      chk(rsp_done && !ext_rd, "R7 done cycle idle", int'({rsp_done, ext_rd}), 2);
      @(posedge clk); #2;   // after E2: still idle (done was high at E2)
      chk(!ext_rd && !rsp_done, "R7 no accept during done", int'({ext_rd, rsp_done}), 0);
      while (!ext_rd && gap < 5) begin
         @(posedge clk); #2; gap++;
      end
      req_valid = 1'b0;
      chk(gap == 1, "R7 second read starts two cycles after end", gap, 1);
      @(posedge clk); #2;
      chk(rsp_done && rsp_rdata == 16'h5A5A, "R7 second read done", int'(rsp_rdata), 16'h5A5A);
      @(posedge clk); #2;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      #1 t_reset;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk) t_reset;
      t_reset_waits;
      access("R1 zero-wait read", 0, 0, 0, 16'h1234, 16'h0F0F, 1);
      access("R2 zero-wait write", 1, 0, 0, 16'h2345, 16'hA5C3, 2);
      access("R4 read ready low 3", 0, 0, 3, 16'h0042, 16'h3C3C, 4);
      access("R4 write ready low 2", 1, 0, 2, 16'h0043, 16'h7E81, 4);
      access("R4 read ready low 20", 0, 0, 20, 16'h0044, 16'h1357, 21);
      access("R6 global read", 0, 1, 2, 16'h8000, 16'h2468, 3);
      access("R6 global write", 1, 1, 1, 16'h8001, 16'hBEEF, 3);
      set_waits(3);
      access("R5 sw3 read", 0, 0, 0, 16'h0100, 16'h0A0A, 4);
      access("R5 sw3 read ready low 5", 0, 0, 5, 16'h0101, 16'h0B0B, 6);
      access("R5 sw3 read ready low 2", 0, 0, 2, 16'h0102, 16'h0C0C, 4);
      access("R5 sw3 write", 1, 0, 0, 16'h0103, 16'h0D0D, 5);
      set_waits(7);
      access("R5 sw7 global write", 1, 1, 0, 16'h0104, 16'h0E0E, 9);
      set_waits(0);
      t_held_request;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule